// File: doc/BRIEF.md
# Address-Sequence Command Decoder

This block sits beside an asynchronous-style memory array and listens to its access stream, already reduced to single-cycle strobes in the system clock domain. A read strobe comes with a 16-bit address. A write strobe comes without one. The block looks for a fixed run of five "key" read addresses followed by a sixth read. The sixth address picks one of seven commands. These are: software store, software recall, powerstore off, powerstore on, and readout of the high, middle or low byte of the last written address. The chosen command is issued as a one-cycle pulse to the logic that carries it out.

Only reads that are qualified by chip enable count. The output-enable state plays no part. Any write, or any read that does not fit the expected position, throws away the progress made so far. The block also holds the powerstore-enable setting in two forms. The live copy follows the on and off commands. The saved copy takes the live value when a software store is issued.

Top module: `seqcmd_decoder`

## Requirements
- R1: After reset every command pulse is 0, and both `ps_en_live` and `ps_en_saved` are 1.
- R2: The key reads 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F, in that order, followed by a read of 0x8FC0, raise `store_pulse` in the cycle after the sixth read strobe, for exactly one cycle.
- R3: The same key reads followed by 0x4C63 raise `recall_pulse` in the same way.
- R4: A final read of 0x8B45 pulses `ps_off_pulse` and clears `ps_en_live`. A final read of 0x4B46 pulses `ps_on_pulse` and sets `ps_en_live`. Both changes are seen in the same cycle as the pulse.
- R5: Final reads of 0x0D30, 0x4D30 and 0x2D30 pulse `wa_hi_pulse`, `wa_mid_pulse` and `wa_lo_pulse` respectively.
- R6: A write strobe at any position aborts the sequence, also when it comes in the same cycle as a read strobe. No command follows from that read.
- R7: A read whose address does not match the expected key aborts the sequence. If that read is 0x4E38, it counts as the first key of a new sequence.
- R8: The sixth read always returns the decoder to idle. A sixth address that is not one of the seven command addresses produces no pulse.
- R9: `ps_en_saved` takes the value of `ps_en_live` at the edge where `store_pulse` rises, and changes at no other time.
- R10: Cycles with neither strobe leave the sequence progress unchanged.
- R11: At most one command pulse is high in any cycle, and no pulse is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | One-cycle strobe for a chip-enabled read |
| rd_addr | input | 16 | Address of the read strobe |
| wr_stb | input | 1 | One-cycle strobe for a chip-enabled write |
| store_pulse | output | 1 | Software store command |
| recall_pulse | output | 1 | Software recall command |
| ps_off_pulse | output | 1 | Powerstore disable command |
| ps_on_pulse | output | 1 | Powerstore enable command |
| wa_hi_pulse | output | 1 | Read high byte of last written address |
| wa_mid_pulse | output | 1 | Read middle byte of last written address |
| wa_lo_pulse | output | 1 | Read low byte of last written address |
| ps_en_live | output | 1 | Volatile powerstore-enable flag |
| ps_en_saved | output | 1 | Powerstore-enable value captured by the last software store |

## Verification
Every result is due exactly one clock edge after the strobe that causes it. A command pulse and any change to either flag appear together after the edge that samples the sixth read. A write or a wrong read has no visible effect at that edge, because the abort only shows up as a missing pulse at a later sixth read. The bench drives each stimulus and then waits for the next rising edge. It applies the same input to its own step model. It compares all seven pulses and both flags at the following falling edge, so each check looks at the value that one register stage has produced from that one input.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;

    localparam int ADDR_W     = 16;
    localparam int PREFIX_LEN = 5;
    localparam int NUM_CMDS   = 7;
    localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_STORE  = 3'd1,
        CMD_RECALL = 3'd2,
        CMD_PS_OFF = 3'd3,
        CMD_PS_ON  = 3'd4,
        CMD_WA_HI  = 3'd5,
        CMD_WA_MID = 3'd6,
        CMD_WA_LO  = 3'd7
    } cmd_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } access_t;

    // Key address expected at a given position of the shared prefix.
    function automatic logic [ADDR_W-1:0] key_addr(input int unsigned pos);
        logic [ADDR_W-1:0] a;
        case (pos)
            0:       a = 16'h4E38;
            1:       a = 16'hB1C7;
            2:       a = 16'h83E0;
            3:       a = 16'h7C1F;
            4:       a = 16'h703F;
            default: a = 16'h0000;
        endcase
        return a;
    endfunction

    // Command selected by the address of the sixth read.
    function automatic cmd_e final_cmd(input logic [ADDR_W-1:0] a);
        cmd_e c;
        case (a)
            16'h8FC0: c = CMD_STORE;
            16'h4C63: c = CMD_RECALL;
            16'h8B45: c = CMD_PS_OFF;
            16'h4B46: c = CMD_PS_ON;
            16'h0D30: c = CMD_WA_HI;
            16'h4D30: c = CMD_WA_MID;
            16'h2D30: c = CMD_WA_LO;
            default:  c = CMD_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/seqcmd_tracker.sv
module seqcmd_tracker
    import seqcmd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  access_t acc,
    output logic    final_rd
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PREFIX_LEN);

    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] step_d;
    logic              key_hit;
    logic              restart_hit;

    assign key_hit     = (acc.addr == key_addr(int'(step_q)));
    assign restart_hit = (acc.addr == key_addr(0));

    always_comb begin
        step_d   = step_q;
        final_rd = 1'b0;
        if (acc.wr) begin
            step_d = '0;
        end else if (acc.rd) begin
            if (step_q == LAST_STEP) begin
                final_rd = 1'b1;
                step_d   = '0;
            end else if (key_hit) begin
                step_d = step_q + 1'b1;
            end else if (restart_hit) begin
                step_d = STEP_W'(1);
            end else begin
                step_d = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= '0;
        else     step_q <= step_d;
    end

    assert_write_abort_R6: assert property (@(posedge clk) disable iff (rst)
        acc.wr |=> (step_q == '0));

    assert_final_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && !acc.wr && step_q == LAST_STEP) |=> (step_q == '0));

    assert_restart_key_R7: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && !acc.wr && step_q != LAST_STEP && acc.addr == 16'h4E38)
        |=> (step_q == STEP_W'(1)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!acc.rd && !acc.wr) |=> $stable(step_q));

    assert_step_range_R8: assert property (@(posedge clk) disable iff (rst)
        step_q <= LAST_STEP);

endmodule

// File: rtl/seqcmd_matcher.sv
module seqcmd_matcher
    import seqcmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                final_rd,
    input  logic [ADDR_W-1:0]   addr,
    output cmd_e                fire,
    output logic [NUM_CMDS-1:0] pulse_q
);

    assign fire = final_rd ? final_cmd(addr) : CMD_NONE;

    for (genvar i = 0; i < NUM_CMDS; i++) begin : g_pulse
        localparam cmd_e MY_CMD = cmd_e'(i + 1);
        always_ff @(posedge clk) begin
            if (rst) pulse_q[i] <= 1'b0;
            else     pulse_q[i] <= (fire == MY_CMD);
        end
    end

    assert_one_cmd_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pulse_q));

    assert_single_cycle_R11: assert property (@(posedge clk) disable iff (rst)
        (|pulse_q) |=> !(|pulse_q));

    assert_no_pulse_without_final_R8: assert property (@(posedge clk) disable iff (rst)
        !final_rd |=> (pulse_q == '0));

endmodule

// File: rtl/seqcmd_psflag.sv
module seqcmd_psflag
    import seqcmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_e fire,
    output logic live_q,
    output logic saved_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q  <= 1'b1;
            saved_q <= 1'b1;
        end else begin
            case (fire)
                CMD_PS_OFF: live_q  <= 1'b0;
                CMD_PS_ON:  live_q  <= 1'b1;
                CMD_STORE:  saved_q <= live_q;
                default: ;
            endcase
        end
    end

    assert_off_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (fire == CMD_PS_OFF) |=> !live_q);

    assert_on_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (fire == CMD_PS_ON) |=> live_q);

    assert_saved_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (fire != CMD_STORE) |=> $stable(saved_q));

    assert_saved_copy_R9: assert property (@(posedge clk) disable iff (rst)
        (fire == CMD_STORE) |=> (saved_q == $past(live_q)));

endmodule

// File: rtl/seqcmd_decoder.sv
module seqcmd_decoder
    import seqcmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_stb,
    input  logic [15:0] rd_addr,
    input  logic        wr_stb,
    output logic        store_pulse,
    output logic        recall_pulse,
    output logic        ps_off_pulse,
    output logic        ps_on_pulse,
    output logic        wa_hi_pulse,
    output logic        wa_mid_pulse,
    output logic        wa_lo_pulse,
    output logic        ps_en_live,
    output logic        ps_en_saved
);

    access_t             acc;
    logic                final_rd;
    cmd_e                fire;
    logic [NUM_CMDS-1:0] pulses;

    assign acc.rd   = rd_stb;
    assign acc.wr   = wr_stb;
    assign acc.addr = rd_addr;

    seqcmd_tracker u_tracker (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .final_rd (final_rd)
    );

    seqcmd_matcher u_matcher (
        .clk      (clk),
        .rst      (rst),
        .final_rd (final_rd),
        .addr     (acc.addr),
        .fire     (fire),
        .pulse_q  (pulses)
    );

    seqcmd_psflag u_psflag (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .live_q  (ps_en_live),
        .saved_q (ps_en_saved)
    );

    assign store_pulse  = pulses[int'(CMD_STORE)  - 1];
    assign recall_pulse = pulses[int'(CMD_RECALL) - 1];
    assign ps_off_pulse = pulses[int'(CMD_PS_OFF) - 1];
    assign ps_on_pulse  = pulses[int'(CMD_PS_ON)  - 1];
    assign wa_hi_pulse  = pulses[int'(CMD_WA_HI)  - 1];
    assign wa_mid_pulse = pulses[int'(CMD_WA_MID) - 1];
    assign wa_lo_pulse  = pulses[int'(CMD_WA_LO)  - 1];

    assert_write_same_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !(store_pulse | recall_pulse | ps_off_pulse | ps_on_pulse |
                     wa_hi_pulse | wa_mid_pulse | wa_lo_pulse));

endmodule

// File: tb/seqcmd_decoder_test.sv
`timescale 1ns/1ps
module seqcmd_decoder_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        rd_stb;
    logic [15:0] rd_addr;
    logic        wr_stb;
    logic        store_pulse, recall_pulse, ps_off_pulse, ps_on_pulse;
    logic        wa_hi_pulse, wa_mid_pulse, wa_lo_pulse;
    logic        ps_en_live, ps_en_saved;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench model state
    int       m_step  = 0;
    logic [6:0] m_pulse = '0;  // store, recall, off, on, hi, mid, lo
    logic     m_live  = 1'b1;
    logic     m_saved = 1'b1;

    always #2.5 clk = ~clk;

    seqcmd_decoder uut (
        .clk(clk), .rst(rst), .rd_stb(rd_stb), .rd_addr(rd_addr), .wr_stb(wr_stb),
        .store_pulse(store_pulse), .recall_pulse(recall_pulse),
        .ps_off_pulse(ps_off_pulse), .ps_on_pulse(ps_on_pulse),
        .wa_hi_pulse(wa_hi_pulse), .wa_mid_pulse(wa_mid_pulse),
        .wa_lo_pulse(wa_lo_pulse), .ps_en_live(ps_en_live), .ps_en_saved(ps_en_saved)
    );

    function automatic logic [15:0] key_of(input int p);
        case (p)
            0: return 16'h4E38;
            1: return 16'hB1C7;
            2: return 16'h83E0;
            3: return 16'h7C1F;
            default: return 16'h703F;
        endcase
    endfunction

    function automatic logic [15:0] final_of(input int k);
        case (k)
            0: return 16'h8FC0;
            1: return 16'h4C63;
            2: return 16'h8B45;
            3: return 16'h4B46;
            4: return 16'h0D30;
            5: return 16'h4D30;
            6: return 16'h2D30;
            default: return 16'h1234;
        endcase
    endfunction

    function automatic string req_of(input int b);
        case (b)
            0: return "R2";
            1: return "R3";
            2, 3: return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic logic [6:0] dut_pulses();
        return {wa_lo_pulse, wa_mid_pulse, wa_hi_pulse, ps_on_pulse,
                ps_off_pulse, recall_pulse, store_pulse};
    endfunction

    task automatic model_edge(input logic rd, input logic wr, input logic [15:0] a);
        m_pulse = '0;
        if (wr) begin
            m_step = 0;
        end else if (rd) begin
            if (m_step == 5) begin
                for (int k = 0; k < 7; k++)
                    if (a == final_of(k)) m_pulse[k] = 1'b1;
                m_step = 0;
            end else if (a == key_of(m_step)) begin
                m_step = m_step + 1;
            end else if (a == 16'h4E38) begin
                m_step = 1;
            end else begin
                m_step = 0;
            end
        end
        if (m_pulse[0]) m_saved = m_live;
        if (m_pulse[2]) m_live = 1'b0;
        if (m_pulse[3]) m_live = 1'b1;
    endtask

    task automatic compare(input string ctx);
        logic [6:0] got;
        got = dut_pulses();
        for (int b = 0; b < 7; b++) begin
            checks++;
            if (got[b] !== m_pulse[b]) begin
                errors++;
                $display("FAIL %s %s pulse bit %0d actual %b expected %b",
                         ctx, req_of(b), b, got[b], m_pulse[b]);
            end
        end
        checks++;
        if (ps_en_live !== m_live) begin
            errors++;
            $display("FAIL %s R4 ps_en_live actual %b expected %b", ctx, ps_en_live, m_live);
        end
        checks++;
        if (ps_en_saved !== m_saved) begin
            errors++;
            $display("FAIL %s R9 ps_en_saved actual %b expected %b", ctx, ps_en_saved, m_saved);
        end
    endtask

    task automatic step(input logic rd, input logic wr, input logic [15:0] a,
                        input string ctx);
        rd_stb  = rd;
        wr_stb  = wr;
        rd_addr = a;
        @(posedge clk);
        model_edge(rd, wr, a);
        @(negedge clk);
        compare(ctx);
    endtask

    task automatic prefix(input string ctx);
        for (int p = 0; p < 5; p++) step(1'b1, 1'b0, key_of(p), ctx);
    endtask

    task automatic expect_pulse(input int b, input string ctx);
        checks++;
        if (dut_pulses() !== (7'd1 << b)) begin
            errors++;
            $display("FAIL %s %s directed pulse actual %b expected %b",
                     ctx, req_of(b), dut_pulses(), 7'd1 << b);
        end
    endtask

    task automatic expect_none(input string ctx);
        checks++;
        if (dut_pulses() !== 7'd0) begin
            errors++;
            $display("FAIL %s no pulse expected actual %b expected 0000000", ctx, dut_pulses());
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; rd_stb = 1'b0; wr_stb = 1'b0; rd_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 reset");
        rst = 1'b0;

        // R2, R3, R4, R5: each command through a clean sequence
        for (int k = 0; k < 7; k++) begin
            prefix("R2 prefix");
            step(1'b1, 1'b0, final_of(k), "R2 R3 R4 R5 final");
            expect_pulse(k, "direct command");
            step(1'b0, 1'b0, 16'h0, "R11 pulse drop");
            expect_none("R11 single cycle");
        end

        // R9: disable then store saves 0; enable then store saves 1
        prefix("R9"); step(1'b1, 1'b0, 16'h8B45, "R9 off");
        prefix("R9"); step(1'b1, 1'b0, 16'h8FC0, "R9 store saves off");
        checks++;
        if (ps_en_saved !== 1'b0) begin
            errors++; $display("FAIL R9 saved actual %b expected 0", ps_en_saved);
        end
        prefix("R9"); step(1'b1, 1'b0, 16'h4B46, "R9 on");
        checks++;
        if (ps_en_saved !== 1'b0) begin
            errors++; $display("FAIL R9 saved changed without store actual %b expected 0", ps_en_saved);
        end

        // R6: write in the middle aborts
        step(1'b1, 1'b0, key_of(0), "R6"); step(1'b1, 1'b0, key_of(1), "R6");
        step(1'b0, 1'b1, 16'h0, "R6 write");
        for (int p = 2; p < 5; p++) step(1'b1, 1'b0, key_of(p), "R6");
        step(1'b1, 1'b0, 16'h8FC0, "R6 after abort");
        expect_none("R6 write abort");

        // R6: write in the same cycle as the sixth read
        prefix("R6");
        step(1'b1, 1'b1, 16'h4C63, "R6 same cycle");
        expect_none("R6 same-cycle write");

        // R7: wrong read restarts when it is the first key
        step(1'b1, 1'b0, key_of(0), "R7"); step(1'b1, 1'b0, key_of(1), "R7");
        step(1'b1, 1'b0, key_of(2), "R7");
        step(1'b1, 1'b0, 16'h4E38, "R7 restart");
        for (int p = 1; p < 5; p++) step(1'b1, 1'b0, key_of(p), "R7");
        step(1'b1, 1'b0, 16'h0D30, "R7 final");
        expect_pulse(4, "R7 restart accepted");

        // R7: wrong non-key read aborts
        step(1'b1, 1'b0, key_of(0), "R7"); step(1'b1, 1'b0, 16'hFFFF, "R7 wrong");
        for (int p = 1; p < 5; p++) step(1'b1, 1'b0, key_of(p), "R7");
        step(1'b1, 1'b0, 16'h2D30, "R7 no pulse");
        expect_none("R7 wrong read abort");

        // R8: unknown sixth address, then idle, then a fresh sequence
        prefix("R8");
        step(1'b1, 1'b0, 16'h4E38, "R8 unknown final");
        expect_none("R8 unknown sixth");
        for (int p = 1; p < 5; p++) step(1'b1, 1'b0, key_of(p), "R8");
        step(1'b1, 1'b0, 16'h4D30, "R8 idle after sixth");
        expect_none("R8 sixth key not a first step");

        // R10: idle gaps between reads
        for (int p = 0; p < 5; p++) begin
            step(1'b1, 1'b0, key_of(p), "R10");
            repeat (3) step(1'b0, 1'b0, 16'hAAAA, "R10 gap");
        end
        step(1'b1, 1'b0, 16'h4D30, "R10 final");
        expect_pulse(5, "R10 gaps tolerated");

        // random mix, R11 checked every cycle through compare
        for (int n = 0; n < 6000; n++) begin
            int r, k;
            logic rd, wr;
            logic [15:0] a;
            r  = int'($urandom % 100);
            rd = (r < 80);
            wr = (r >= 80 && r < 84);
            k  = int'($urandom % 10);
            if (k < 7) a = (m_step < 5) ? key_of(m_step) : final_of(int'($urandom % 8));
            else if (k == 7) a = 16'h4E38;
            else a = 16'($urandom);
            step(rd, wr, a, "random R11");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule